// File: doc/BRIEF.md
# Prescaled Overflow Timer

This block is an up-counter that advances once every 2^`PRESC_EXP` system clocks while it runs. Software loads a start count with a load strobe, starts the count with a start strobe and halts it with a stop strobe. The count can be read at any time on `count`.

When the count passes from its all-ones value to zero it sets a sticky timer flag. That flag is the interrupt request towards the interrupt logic. The same flag can be sampled by a test-and-branch instruction. Either consumer clears it by pulsing `flag_clr`. The counter keeps running after a wrap until it is stopped or reset.

The prescale exponent is fixed at build time. It must lie in 0..13, and the value 6 is reserved. An illegal value stops elaboration.

Top module: `ovf_timer`

## Requirements
- R1: After reset `count` is 0, `flag` is 0 and the timer is stopped, so `count` does not move until a start strobe.
- R2: While running, `count` increments by one exactly once per 2^`PRESC_EXP` clocks. The first increment comes at the 2^`PRESC_EXP`-th rising edge after the edge that samples `on_stb`.
- R3: While stopped, `count` holds its value unless a load is applied.
- R4: A `load_stb` writes `load_val` into `count` at the next edge and restarts the prescale phase, so the next increment comes a full 2^`PRESC_EXP` clocks later. A load wins over an increment in the same cycle.
- R5: From the all-ones value an increment gives 0, and counting then continues upward.
- R6: The increment from all-ones to zero sets `flag` at the same edge.
- R7: `flag_clr` clears `flag` at the next edge. If an overflow happens in that same cycle, `flag` stays set.
- R8: `off_stb` stops the timer and wins over a simultaneous `on_stb`. Stopping leaves `flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_stb | input | 1 | Write `load_val` into the counter |
| load_val | input | CNT_W | Start count to load |
| on_stb | input | 1 | Start counting |
| off_stb | input | 1 | Stop counting |
| flag_clr | input | 1 | Clear the timer flag (interrupt taken or flag tested) |
| count | output | CNT_W | Current counter value |
| flag | output | 1 | Sticky overflow flag and interrupt request |

## Verification
Directed patterns run the counter from just below all-ones through the wrap. This separates a correct prescale period from an off-by-one first tick, and a true wrap from a saturating counter. A load issued in the middle of a prescale period shows whether the phase restarts. A clear placed on the exact overflow cycle exposes the wrong set/clear priority. A start and stop in the same cycle shows which strobe wins. A long run of random strobes, with start values biased towards all-ones, is then compared cycle by cycle against a bench model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned PRESC_MAX      = 13;
   localparam int unsigned PRESC_RESERVED = 6;

   function automatic bit presc_legal(input int unsigned e);
      return (e <= PRESC_MAX) && (e != PRESC_RESERVED);
   endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int unsigned PRESC_EXP = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic on_stb,
   input  logic off_stb,
   input  logic load_stb,
   output logic tick
);
   logic run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= 1'b0;
      else if (off_stb) run_q <= 1'b0;
      else if (on_stb)  run_q <= 1'b1;
   end

   generate
      if (PRESC_EXP == 0) begin : g_direct
         assign tick = run_q;
      end else begin : g_divide
         logic [PRESC_EXP-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   phase_q <= '0;
            else if (load_stb || !run_q)  phase_q <= '0;
            else                          phase_q <= phase_q + 1'b1;
         end
         assign tick = run_q && (&phase_q);
      end
   endgenerate

   AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      off_stb |=> !run_q); // R8
   AST_ON_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (on_stb && !off_stb) |=> run_q); // R2
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load_stb,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= '0;
      else if (load_stb) count <= load_val;
      else if (tick)     count <= count + 1'b1;
   end

   assign wrap = tick && !load_stb && (count == CNT_TOP);

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load_stb) |=> $stable(count)); // R3
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_stb) |=> count == $past(count) + 1'b1); // R2
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> count == $past(load_val)); // R4
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic flag_clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (wrap)     flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   AST_SET_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag); // R6
   AST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !wrap) |=> !flag); // R7
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag); // R8
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer #(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned PRESC_EXP = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_stb,
   input  logic [CNT_W-1:0] load_val,
   input  logic             on_stb,
   input  logic             off_stb,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             flag
);
   import tmr_pkg::*;

   generate
      if (!presc_legal(PRESC_EXP)) begin : g_bad_presc
         $error("ovf_timer: PRESC_EXP must be 0..13 and not 6");
      end
      if (CNT_W < 2) begin : g_bad_width
         $error("ovf_timer: CNT_W must be at least 2");
      end
   endgenerate

   logic tick;
   logic wrap;

   tmr_prescale #(.PRESC_EXP(PRESC_EXP)) i_prescale (
      .clk(clk), .rst_n(rst_n), .on_stb(on_stb), .off_stb(off_stb),
      .load_stb(load_stb), .tick(tick));

   tmr_count #(.CNT_W(CNT_W)) i_count (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load_stb(load_stb),
      .load_val(load_val), .count(count), .wrap(wrap));

   tmr_flag i_flag (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .flag_clr(flag_clr), .flag(flag));

   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_stb && (&count)) |=> (count == '0) && flag); // R5
endmodule

// File: tb/test_ovf_timer.sv
`timescale 1ns/1ps
module test_ovf_timer;
   localparam int E = 3;
   localparam int P = 1 << E;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_stb = 1'b0, on_stb = 1'b0, off_stb = 1'b0, flag_clr = 1'b0;
   logic [7:0] load_val = '0;
   logic [7:0] count;
   logic       flag;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference state
   bit       m_run = 0, m_flag = 0;
   int       m_pre = 0;
   bit [7:0] m_cnt = 0;

   always #2 clk = ~clk;

   ovf_timer #(.CNT_W(8), .PRESC_EXP(E)) i_ovf_timer (
      .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_val(load_val),
      .on_stb(on_stb), .off_stb(off_stb), .flag_clr(flag_clr),
      .count(count), .flag(flag));

   function automatic bit [7:0] next_cnt(bit [7:0] c, bit ld, bit [7:0] v, bit tk);
      if (ld) return v;
      if (tk) return c + 8'd1;
      return c;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // called at a negedge: drive, let an edge pass, update model, compare at next negedge
   task automatic cyc(bit ld, bit [7:0] v, bit on, bit off, bit clr, string tag);
      bit tk, ovf;
      load_stb = ld; load_val = v; on_stb = on; off_stb = off; flag_clr = clr;
      @(posedge clk);
      tk  = m_run && (m_pre == P - 1);
      ovf = tk && !ld && (m_cnt == 8'hFF);
      m_cnt = next_cnt(m_cnt, ld, v, tk);
      if (ovf) m_flag = 1;
      else if (clr) m_flag = 0;
      if (ld || !m_run || tk) m_pre = 0; else m_pre = m_pre + 1;
      if (off) m_run = 0; else if (on) m_run = 1;
      @(negedge clk);
      chk({tag, " count"}, count, m_cnt);
      chk({tag, " flag"}, flag, m_flag);
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 0, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      #9;
      @(negedge clk);
      chk("R1 reset count", count, 0);
      chk("R1 reset flag", flag, 0);
      rst_n = 1'b1;
      idle(5, "R1 stays stopped");
      chk("R3 idle count", count, 8'h00);

      cyc(1, 8'hFD, 0, 0, 0, "R4 load");
      chk("R4 load value", count, 8'hFD);
      cyc(0, 8'h00, 1, 0, 0, "R2 start");
      idle(P - 1, "R2 before first tick");
      chk("R2 no early tick", count, 8'hFD);
      idle(1, "R2 first tick");
      chk("R2 first tick", count, 8'hFE);
      idle(P, "R2 second tick");
      chk("R2 second tick", count, 8'hFF);
      chk("R6 no early flag", flag, 0);
      idle(P, "R5 wrap");
      chk("R5 wrap to zero", count, 8'h00);
      chk("R6 flag on wrap", flag, 1);
      idle(P, "R5 continue");
      chk("R5 counts on", count, 8'h01);

      cyc(0, 8'h00, 0, 0, 1, "R7 clear");
      chk("R7 clear flag", flag, 0);

      cyc(1, 8'hFF, 0, 0, 0, "R7 preload");
      idle(P - 1, "R7 approach");
      cyc(0, 8'h00, 0, 0, 1, "R7 clear vs wrap");
      chk("R7 set wins over clear", flag, 1);
      chk("R5 wrap with clear", count, 8'h00);

      idle(3, "R4 mid phase");
      cyc(1, 8'h10, 0, 0, 0, "R4 reload running");
      idle(P - 1, "R4 phase restarted");
      chk("R4 phase restart hold", count, 8'h10);
      idle(1, "R4 tick after reload");
      chk("R4 tick after reload", count, 8'h11);

      cyc(0, 8'h00, 1, 1, 0, "R8 on+off");
      idle(3 * P, "R8 stopped");
      chk("R8 off wins", count, 8'h11);
      chk("R8 flag kept", flag, 1);
      cyc(1, 8'h42, 0, 0, 0, "R3 load while stopped");
      idle(2 * P, "R3 stopped hold");
      chk("R3 stopped load holds", count, 8'h42);

      for (int i = 0; i < 4000; i++) begin
         int r = $urandom_range(0, 999);
         bit ld = (r < 25);
         bit on = ($urandom_range(0, 99) < 4);
         bit off = ($urandom_range(0, 99) < 2);
         bit clr = ($urandom_range(0, 99) < 8);
         bit [7:0] v = ($urandom_range(0, 1) != 0) ? 8'(8'hF8 + $urandom_range(0, 7))
                                                   : 8'($urandom_range(0, 255));
         cyc(ld, v, on, off, clr, "R2/R4/R6/R7 random");
      end

      rst_n = 1'b0;
      m_run = 0; m_flag = 0; m_pre = 0; m_cnt = 0;
      @(negedge clk);
      chk("R1 reset again count", count, 0);
      chk("R1 reset again flag", flag, 0);
      finish_run();
   end
endmodule